// File: doc/BRIEF.md
# Cascadable GPIO Bit Sequencer Group

This block holds a group of four bit sequencers that sit beside a bank of general purpose I/O lines. Each sequencer owns a 32-bit pattern register and either plays that pattern out onto its line, least significant bit first, or records what arrives on its line into the pattern register. A shared bit-rate tick paces every sequencer at one bit per tick. A shared start pulse launches every armed chain head. While a chain runs it owns its line. When the chain finishes, the line goes back to ordinary GPIO control.

A sequencer can be linked to the next one up in the group, so a stream longer than 32 bits flows through consecutive pattern registers. Up to four sequencers chain into one stream of up to 128 bits. Only the lowest sequencer of a chain (its head) uses a physical line, and the linked members leave their own lines free. A per-chain done flag reports completion. Configuration goes through a simple write port, and every pattern register can be read back on a flat bus.

Top module: `gseq_group`

## Requirements
- R1: After reset every line is released (`pin_own`, `pin_oe` and `pin_out` all 0), every done flag is 0 and every pattern register reads 0.
- R2: A write (`wr_en`) loads the pattern, length code, direction (1 = drive, 0 = sample), arm bit and link bit of sequencer `wr_sel`. The pattern reads back on `pattern_rd[32*i +: 32]`. A write issued while any sequencer of the group is running is ignored.
- R3: A one-cycle `start` launches every armed head. A head is sequencer 0, or any sequencer whose lower neighbour has link = 0. A `start` issued while any sequencer is running is ignored, and the running stream continues unchanged.
- R4: In drive mode, bit 0 of the pattern appears on the head's `pin_out` two cycles after `start`, with `pin_oe` = 1 and `pin_own` = 1. Each tick advances one bit, and the pattern register rotates right by one bit per tick.
- R5: Length code n on the last sequencer of a chain gives n+1 bits from that sequencer. Every sequencer that links onward runs all 32 bits, whatever its length code.
- R6: With link = 1 on sequencer i, sequencer i+1 continues the stream on the head's line, with no gap, after sequencer i's last bit. The link bit of the top sequencer is ignored, so four linked sequencers give 128 bits.
- R7: A sequencer whose lower neighbour has link = 1 never drives or claims its own line: its `pin_own`, `pin_oe` and `pin_out` stay 0.
- R8: In sample mode, the head line is resynchronised through two flip-flops. On the k-th tick of a sequencer, the synchronised value is written into bit k of that sequencer's pattern register, and bits that are not reached keep their contents. While sampling, `pin_own` = 1 and `pin_oe` = 0.
- R9: The head's `seq_done` flag rises on the tick that ends the last bit of its chain, and stays set until that head is launched again. `pin_own` falls one cycle after completion.
- R10: An unarmed head is not launched by `start`, and its line stays released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | Bit-rate strobe, one bit per pulse |
| start | input | 1 | Launch pulse for armed chain heads |
| wr_en | input | 1 | Configuration write strobe |
| wr_sel | input | 2 | Sequencer addressed by the write |
| wr_pattern | input | 32 | Pattern value to load |
| wr_len | input | 5 | Length code, bits = code + 1 |
| wr_dir | input | 1 | 1 = drive pattern, 0 = sample line |
| wr_arm | input | 1 | Arm bit, heads only |
| wr_link | input | 1 | Chain into the next sequencer up |
| pin_in | input | 4 | Raw line inputs |
| pin_out | output | 4 | Registered line output values |
| pin_oe | output | 4 | Registered line output enables |
| pin_own | output | 4 | Line held by a running sequencer |
| seq_done | output | 4 | Chain completion flag per head |
| pattern_rd | output | 128 | All pattern registers, sequencer i at bits 32*i+31..32*i |

## Verification
A wrong bit counter or a broken handoff shows on the head's line within one tick window: a bit is repeated, skipped or taken from the wrong register, and the bench compares every window of every stream against a queue of expected bits. A member that wrongly claims its line shows on its own `pin_own` or `pin_oe` in the first window of the chain. A sampler that writes to the wrong index, or an illegal write or restart, shows in the read-back pattern and the done flag once the chain has ended, a few cycles after the last tick.

// File: rtl/gseq_pkg.sv
package gseq_pkg;
  localparam int GSEQ_LANES = 4;
  localparam int GSEQ_BITS  = 32;
  typedef enum logic {
    DIR_SAMPLE = 1'b0,
    DIR_DRIVE  = 1'b1
  } gseq_dir_e;
endpackage

// File: rtl/gseq_sync.sv
module gseq_sync #(
  parameter int N = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] d,
  output logic [N-1:0] q
);
  logic [N-1:0] meta_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      meta_q <= '0;
      q      <= '0;
    end else begin
      meta_q <= d;
      q      <= meta_q;
    end
  end
endmodule

// File: rtl/gseq_lane.sv
module gseq_lane
  import gseq_pkg::*;
#(
  parameter int W  = GSEQ_BITS,
  parameter int LW = $clog2(W)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          tick,
  input  logic          wr_load,
  input  logic [W-1:0]  wr_pattern,
  input  logic [LW-1:0] wr_len,
  input  logic          wr_dir,
  input  logic          wr_arm,
  input  logic          wr_link,
  input  logic          launch,
  input  logic          handoff_in,
  input  logic          drive_mode,
  input  logic          is_last,
  input  logic          sample_bit,
  output logic          active,
  output logic [W-1:0]  pat,
  output logic          dir,
  output logic          arm,
  output logic          link,
  output logic          handoff_out,
  output logic          finish
);
  logic [LW-1:0] cnt_q;
  logic [LW-1:0] len_q;
  logic          end_here;
  logic          step;

  assign step        = tick & active;
  assign end_here    = is_last ? (cnt_q == len_q) : (cnt_q == LW'(W - 1));
  assign handoff_out = step & end_here & ~is_last;
  assign finish      = step & end_here & is_last;

  always_ff @(posedge clk) begin
    if (rst) begin
      active <= 1'b0;
      pat    <= '0;
      cnt_q  <= '0;
      len_q  <= '0;
      dir    <= 1'b0;
      arm    <= 1'b0;
      link   <= 1'b0;
    end else begin
      if (wr_load) begin
        pat   <= wr_pattern;
        len_q <= wr_len;
        dir   <= wr_dir;
        arm   <= wr_arm;
        link  <= wr_link;
      end
      if (launch || handoff_in) begin
        active <= 1'b1;
        cnt_q  <= '0;
      end else if (step) begin
        if (drive_mode == DIR_DRIVE) pat <= {pat[0], pat[W-1:1]};
        else                         pat[cnt_q] <= sample_bit;
        if (end_here) active <= 1'b0;
        else          cnt_q  <= cnt_q + 1'b1;
      end
    end
  end

  // R2
  cfg_lock_chk: assert property (@(posedge clk) disable iff (rst)
    active |=> ($stable(len_q) && $stable(link) && $stable(dir)));

  // R5
  cnt_bound_chk: assert property (@(posedge clk) disable iff (rst)
    (active && is_last) |-> (cnt_q <= len_q));
endmodule

// File: rtl/gseq_route.sv
module gseq_route #(
  parameter int N  = 4,
  parameter int SW = $clog2(N)
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] link,
  input  logic [N-1:0] active,
  input  logic [N-1:0] lsb,
  input  logic [N-1:0] dir,
  input  logic [N-1:0] sync_in,
  input  logic [N-1:0] finish,
  output logic [N-1:0] is_head,
  output logic [N-1:0] is_last,
  output logic [N-1:0] lane_drive,
  output logic [N-1:0] lane_sample,
  output logic [N-1:0] pin_bit,
  output logic [N-1:0] pin_busy,
  output logic [N-1:0] done_hit
);
  logic [SW-1:0] head_of [N];
  logic [N-1:0]  member  [N];

  always_comb begin
    head_of[0] = '0;
    for (int i = 1; i < N; i++)
      head_of[i] = link[i-1] ? head_of[i-1] : SW'(i);
  end

  always_comb begin
    for (int h = 0; h < N; h++)
      for (int j = 0; j < N; j++)
        member[h][j] = (head_of[j] == SW'(h));
  end

  genvar i;
  generate
    for (i = 0; i < N; i++) begin : g_lane
      if (i == 0) begin : g_bottom
        assign is_head[i] = 1'b1;
      end else begin : g_upper
        assign is_head[i] = ~link[i-1];
      end
      if (i == N - 1) begin : g_top
        assign is_last[i] = 1'b1;
      end else begin : g_mid
        assign is_last[i] = ~link[i];
      end
      assign lane_drive[i]  = dir[head_of[i]];
      assign lane_sample[i] = sync_in[head_of[i]];
      assign pin_bit[i]     = |(member[i] & active & lsb);
      assign pin_busy[i]    = |(member[i] & active);
      assign done_hit[i]    = |(member[i] & finish);

      // R6
      one_token_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0(member[i] & active));
    end
  endgenerate
endmodule

// File: rtl/gseq_group.sv
module gseq_group
  import gseq_pkg::*;
#(
  parameter int LANES = GSEQ_LANES,
  parameter int BITS  = GSEQ_BITS,
  localparam int SW   = $clog2(LANES),
  localparam int LW   = $clog2(BITS)
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  tick,
  input  logic                  start,
  input  logic                  wr_en,
  input  logic [SW-1:0]         wr_sel,
  input  logic [BITS-1:0]       wr_pattern,
  input  logic [LW-1:0]         wr_len,
  input  logic                  wr_dir,
  input  logic                  wr_arm,
  input  logic                  wr_link,
  input  logic [LANES-1:0]      pin_in,
  output logic [LANES-1:0]      pin_out,
  output logic [LANES-1:0]      pin_oe,
  output logic [LANES-1:0]      pin_own,
  output logic [LANES-1:0]      seq_done,
  output logic [LANES*BITS-1:0] pattern_rd
);
  logic [LANES-1:0] active, lsb, dir, arm, link;
  logic [LANES-1:0] handoff, finish, launch, wr_load;
  logic [LANES-1:0] is_head, is_last, lane_drive, lane_sample;
  logic [LANES-1:0] pin_bit, pin_busy, done_hit, sync_in;
  logic             busy;

  assign busy = |active;

  gseq_sync #(.N(LANES)) u_sync (
    .clk(clk), .rst(rst), .d(pin_in), .q(sync_in)
  );

  gseq_route #(.N(LANES), .SW(SW)) u_route (
    .clk(clk), .rst(rst), .link(link), .active(active), .lsb(lsb),
    .dir(dir), .sync_in(sync_in), .finish(finish), .is_head(is_head),
    .is_last(is_last), .lane_drive(lane_drive), .lane_sample(lane_sample),
    .pin_bit(pin_bit), .pin_busy(pin_busy), .done_hit(done_hit)
  );

  genvar i;
  generate
    for (i = 0; i < LANES; i++) begin : g_seq
      logic [BITS-1:0] pat;
      logic            hand_in;

      if (i == 0) begin : g_first
        assign hand_in = 1'b0;
      end else begin : g_next
        assign hand_in = handoff[i-1];
      end

      assign wr_load[i] = wr_en & ~busy & (wr_sel == SW'(i));
      assign launch[i]  = start & ~busy & is_head[i] & arm[i];
      assign lsb[i]     = pat[0];
      assign pattern_rd[i*BITS +: BITS] = pat;

      gseq_lane #(.W(BITS), .LW(LW)) u_lane (
        .clk(clk), .rst(rst), .tick(tick), .wr_load(wr_load[i]),
        .wr_pattern(wr_pattern), .wr_len(wr_len), .wr_dir(wr_dir),
        .wr_arm(wr_arm), .wr_link(wr_link), .launch(launch[i]),
        .handoff_in(hand_in), .drive_mode(lane_drive[i]),
        .is_last(is_last[i]), .sample_bit(lane_sample[i]),
        .active(active[i]), .pat(pat), .dir(dir[i]), .arm(arm[i]),
        .link(link[i]), .handoff_out(handoff[i]), .finish(finish[i])
      );

      always_ff @(posedge clk) begin
        if (rst) begin
          pin_out[i]  <= 1'b0;
          pin_oe[i]   <= 1'b0;
          pin_own[i]  <= 1'b0;
          seq_done[i] <= 1'b0;
        end else begin
          pin_out[i]  <= pin_busy[i] & dir[i] & pin_bit[i];
          pin_oe[i]   <= pin_busy[i] & dir[i];
          pin_own[i]  <= pin_busy[i];
          if (launch[i])        seq_done[i] <= 1'b0;
          else if (done_hit[i]) seq_done[i] <= 1'b1;
        end
      end

      // R4
      oe_own_chk: assert property (@(posedge clk) disable iff (rst)
        pin_oe[i] |-> pin_own[i]);

      // R9
      done_clear_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(seq_done[i]) |-> $past(start));

      if (i > 0) begin : g_member_chk
        // R7
        member_quiet_chk: assert property (@(posedge clk) disable iff (rst)
          link[i-1] |-> (!pin_own[i] && !pin_oe[i] && !pin_out[i]));
      end
    end
  endgenerate
endmodule

// File: tb/gseq_group_test.sv
module gseq_group_test;
  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         tick = 1'b0, start = 1'b0, wr_en = 1'b0;
  logic [1:0]   wr_sel = '0;
  logic [31:0]  wr_pattern = '0;
  logic [4:0]   wr_len = '0;
  logic         wr_dir = 1'b0, wr_arm = 1'b0, wr_link = 1'b0;
  logic [3:0]   pin_in = '0;
  logic [3:0]   pin_out, pin_oe, pin_own, seq_done;
  logic [127:0] pattern_rd;

  int tests = 0, fails = 0;
  logic [2:0] expq[$];
  logic       sbits [0:127];

  always #2 clk = ~clk;

  gseq_group uut (
    .clk(clk), .rst(rst), .tick(tick), .start(start), .wr_en(wr_en),
    .wr_sel(wr_sel), .wr_pattern(wr_pattern), .wr_len(wr_len),
    .wr_dir(wr_dir), .wr_arm(wr_arm), .wr_link(wr_link), .pin_in(pin_in),
    .pin_out(pin_out), .pin_oe(pin_oe), .pin_own(pin_own),
    .seq_done(seq_done), .pattern_rd(pattern_rd)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] rotr(input logic [31:0] p, input int n);
    if (n % 32 == 0) return p;
    return (p >> (n % 32)) | (p << (32 - (n % 32)));
  endfunction

  function automatic logic [31:0] rd(input int i);
    return pattern_rd[i*32 +: 32];
  endfunction

  task automatic wr(input int sel, input logic [31:0] p, input int len,
                    input logic d, input logic a, input logic l);
    @(negedge clk);
    wr_en = 1'b1; wr_sel = 2'(sel); wr_pattern = p; wr_len = 5'(len);
    wr_dir = d; wr_arm = a; wr_link = l;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic go();
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
  endtask

  task automatic push_drive(input logic [31:0] p, input int c);
    for (int b = 0; b < c; b++) expq.push_back({2'b11, p[b]});
  endtask

  task automatic push_smp(input int c);
    for (int b = 0; b < c; b++) expq.push_back(3'b100);
  endtask

  // Monitor: pops one expected line state per tick window and compares it.
  task automatic run_chain(input int h, input bit smp, input logic [3:0] members,
                           input int poke_at);
    int k = 0;
    while (expq.size() > 0) begin
      logic [2:0] e;
      @(negedge clk);
      if (smp) pin_in[h] = sbits[k];
      @(negedge clk);
      @(negedge clk);
      e = expq.pop_front();
      check(smp ? "R8 line state" : "R4/R5/R6 line bit",
            {29'd0, pin_own[h], pin_oe[h], pin_out[h]}, {29'd0, e});
      for (int j = 0; j < 4; j++)
        if (members[j])
          check("R7 member line", {29'd0, pin_own[j], pin_oe[j], pin_out[j]}, 32'd0);
      if (k == poke_at) begin
        // R2/R3: write and restart while running must be ignored
        wr(h, 32'hFFFF_FFFF, 0, 1'b1, 1'b1, 1'b0);
        go();
      end
      tick = 1'b1;
      @(negedge clk);
      tick = 1'b0;
      k++;
    end
    @(negedge clk);
    @(negedge clk);
    check("R9 line released", {31'd0, pin_own[h]}, 32'd0);
    check("R9 done set", {31'd0, seq_done[h]}, 32'd1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    logic [31:0] s2, s3;
    for (int k = 0; k < 128; k++) sbits[k] = ((k * 37) ^ (k >> 2) ^ (k >> 4)) & 1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R1 reset state
    check("R1 pin_own", {28'd0, pin_own}, 32'd0);
    check("R1 pin_oe", {28'd0, pin_oe}, 32'd0);
    check("R1 pin_out", {28'd0, pin_out}, 32'd0);
    check("R1 done", {28'd0, seq_done}, 32'd0);
    for (int i = 0; i < 4; i++) check("R1 pattern", rd(i), 32'd0);

    // R10: start with nothing armed keeps all lines free
    go();
    repeat (3) @(negedge clk);
    check("R10 unarmed idle", {28'd0, pin_own}, 32'd0);

    // Single drive sequencer, 8 bits
    wr(0, 32'h0000_00A5, 7, 1'b1, 1'b1, 1'b0);
    check("R2 readback", rd(0), 32'h0000_00A5);
    go();
    push_drive(32'h0000_00A5, 8);
    run_chain(0, 1'b0, 4'b0000, -1);
    check("R4 rotate", rd(0), rotr(32'h0000_00A5, 8));

    // Relaunch; mid-run write and restart ignored
    wr(0, 32'h0000_1234, 11, 1'b1, 1'b1, 1'b0);
    go();
    @(negedge clk);
    check("R9 done cleared on launch", {31'd0, seq_done[0]}, 32'd0);
    push_drive(32'h0000_1234, 12);
    run_chain(0, 1'b0, 4'b0000, 5);
    check("R2 busy write ignored", rd(0), rotr(32'h0000_1234, 12));

    // Cascade 0->1->2, lane 3 unarmed head
    wr(0, 32'hC0DE_1A2B, 5, 1'b1, 1'b1, 1'b1);
    wr(1, 32'h9E37_79B9, 9, 1'b1, 1'b0, 1'b1);
    wr(2, 32'h0000_000D, 3, 1'b1, 1'b0, 1'b0);
    wr(3, 32'h5555_5555, 2, 1'b1, 1'b0, 1'b0);
    go();
    push_drive(32'hC0DE_1A2B, 32);
    push_drive(32'h9E37_79B9, 32);
    push_drive(32'h0000_000D, 4);
    run_chain(0, 1'b0, 4'b0110, -1);
    check("R10 unarmed head idle", {31'd0, pin_own[3]}, 32'd0);
    check("R5 full member lane0", rd(0), 32'hC0DE_1A2B);
    check("R5 full member lane1", rd(1), 32'h9E37_79B9);
    check("R5 last lane rotate", rd(2), rotr(32'h0000_000D, 4));

    // Sampler chain 2->3
    wr(0, 32'h0, 0, 1'b1, 1'b0, 1'b0);
    wr(1, 32'h0, 0, 1'b1, 1'b0, 1'b0);
    wr(2, 32'h1234_5678, 0, 1'b0, 1'b1, 1'b1);
    wr(3, 32'hFFFF_0000, 4, 1'b0, 1'b0, 1'b0);
    check("R2 readback lane3", rd(3), 32'hFFFF_0000);
    go();
    push_smp(37);
    run_chain(2, 1'b1, 4'b1000, -1);
    s2 = '0;
    s3 = 32'hFFFF_0000;
    for (int k = 0; k < 32; k++) s2[k] = sbits[k];
    for (int k = 0; k < 5; k++) s3[k] = sbits[32 + k];
    check("R8 sampled lane2", rd(2), s2);
    check("R8 sampled lane3 keeps upper bits", rd(3), s3);
    check("R9 member has no done", {31'd0, seq_done[3]}, 32'd0);

    // Full 128-bit chain, top link ignored
    wr(0, 32'h0F1E_2D3C, 0, 1'b1, 1'b1, 1'b1);
    wr(1, 32'h8421_7BDE, 0, 1'b1, 1'b0, 1'b1);
    wr(2, 32'hA5A5_0FF0, 0, 1'b1, 1'b0, 1'b1);
    wr(3, 32'h1357_9BDF, 31, 1'b1, 1'b0, 1'b1);
    go();
    push_drive(32'h0F1E_2D3C, 32);
    push_drive(32'h8421_7BDE, 32);
    push_drive(32'hA5A5_0FF0, 32);
    push_drive(32'h1357_9BDF, 32);
    run_chain(0, 1'b0, 4'b1110, -1);
    check("R6 128-bit lane3 restored", rd(3), 32'h1357_9BDF);
    check("R6 128-bit lane0 restored", rd(0), 32'h0F1E_2D3C);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule